// File: doc/BRIEF.md
# Banked Internal Data Memory Unit

This block is the on-chip data store of a small 8-bit controller core. It holds 128 bytes of general RAM and a separate window of 128 register addresses in which a handful of special-function cells are built. A single 8-bit operand address arrives with an access-kind code, and the unit decides where that address lands. A banked working register lands in one of 32 low RAM bytes, chosen by the current bank. A direct address lands in RAM or in the register window. An indirect pointer reaches RAM only. A bit address lands in the bit-addressable RAM area or in an 8-aligned register cell.

The stack also lives in RAM. Its top is tracked by an 8-bit stack pointer, and that pointer is itself one of the register cells, so direct accesses can read and reload it. Each cycle the core issues at most one request. A read returns its byte one cycle later. A write, including a single-bit write that changes only the named bit, takes effect at the clock edge that accepts it. Opcode decoding, arithmetic and program or external memory belong to other blocks.

Top module: `idm_unit`

## Requirements
- R1: While reset is high and in the cycle after it, the stack pointer (register address 0x81) holds 0x07 and rsp_valid is 0.
- R2: Kind code 0 (banked register) accesses RAM byte bank_sel*8 + req_addr[2:0]. Bits req_addr[7:3] are ignored.
- R3: Kind code 1 (direct) with an address below 0x80, and kind code 2 (indirect) with an address below 0x80, both access RAM byte req_addr. Both kinds reach the same storage.
- R4: Kind code 1 with an address of 0x80 or above accesses the register window. Implemented cells are 0x80, 0x81 (stack pointer), 0x82, 0x83, 0x90, 0xA0, 0xB0, 0xD0, 0xE0 and 0xF0. A read of any other register address returns 0x00, and a write to one has no effect.
- R5: Kind code 2 with an address of 0x80 or above reads 0x00, and a write with that address changes no storage.
- R6: Kind code 3 (bit) with a bit address b below 0x80 uses RAM byte 0x20 + (b>>3), bit b[2:0]. A bit write stores req_wbit in that bit only. A bit read returns the whole byte on rsp_data and the addressed bit on rsp_bit.
- R7: Kind code 3 with b of 0x80 or above uses register address b & 0xF8, bit b[2:0], under the same rules. If that address has no implemented cell, the read returns 0 and the write is ignored.
- R8: Kind code 4 (push) first increments the stack pointer and then writes req_wdata to RAM at the new pointer. Kind code 5 (pop) returns the RAM byte at the pointer and then decrements it. The pointer wraps modulo 256.
- R9: A push whose incremented pointer is 0x80 or above writes nothing, and a pop with a pointer of 0x80 or above returns 0x00. In both cases the pointer still moves.
- R10: A request yields rsp_valid = 1 with its data exactly one cycle later when it is a pop, or a non-push request with req_we = 0. Every other cycle has rsp_valid = 0. A write is visible to the very next request.
- R11: Kind codes 6 and 7 change no storage and no pointer. As reads they return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | Access kind code (0 reg, 1 direct, 2 indirect, 3 bit, 4 push, 5 pop) |
| req_addr | input | 8 | Operand address, register index or bit address |
| req_we | input | 1 | Write when 1, read when 0 (push and pop ignore it) |
| req_wdata | input | 8 | Byte write data, push data |
| req_wbit | input | 1 | Value for a single-bit write |
| bank_sel | input | 2 | Current working-register bank |
| rsp_valid | output | 1 | Read response present |
| rsp_data | output | 8 | Read response byte |
| rsp_bit | output | 1 | Addressed bit of a bit read, 0 otherwise |

## Verification
Every read response, including pops and reads that return zero, is due in the cycle after its request. A write or a pointer move must be seen by the request issued in the very next cycle. The bench drives each request on a falling edge and samples the response on the next falling edge, which is exactly one rising edge later. It issues requests back to back, so each read also confirms that the previous cycle's write has landed. The reference model is updated in request order, so every expected value already includes every earlier write and pointer move.

// File: rtl/idm_pkg.sv
package idm_pkg;

  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 8;
  localparam int RAM_AW  = ADDR_W - 1;
  localparam int BANK_W  = 2;
  localparam int REG_W   = 3;
  localparam int BPOS_W  = 3;

  localparam logic [2:0] KIND_REG  = 3'd0;
  localparam logic [2:0] KIND_DIR  = 3'd1;
  localparam logic [2:0] KIND_IND  = 3'd2;
  localparam logic [2:0] KIND_BIT  = 3'd3;
  localparam logic [2:0] KIND_PUSH = 3'd4;
  localparam logic [2:0] KIND_POP  = 3'd5;

  localparam logic [RAM_AW-1:0] BIT_RAM_BASE = 7'h20;
  localparam logic [ADDR_W-1:0] SP_ADDR      = 8'h81;
  localparam logic [DATA_W-1:0] SP_RESET     = 8'h07;

  localparam int SFR_COUNT = 10;
  localparam logic [ADDR_W-1:0] SFR_MAP [SFR_COUNT] = '{
    8'h80, 8'h81, 8'h82, 8'h83, 8'h90, 8'hA0, 8'hB0, 8'hD0, 8'hE0, 8'hF0
  };

  typedef struct packed {
    logic              ram_hit;
    logic              sfr_hit;
    logic [RAM_AW-1:0] ram_addr;
    logic [ADDR_W-1:0] sfr_addr;
    logic              is_bit;
    logic [BPOS_W-1:0] bit_pos;
    logic              is_read;
    logic              is_write;
    logic              push;
    logic              pop;
  } route_t;

endpackage

// File: rtl/idm_route.sv
module idm_route
  import idm_pkg::*;
(
  input  logic [2:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BANK_W-1:0] bank,
  input  logic [DATA_W-1:0] sp,
  output route_t            rt
);

  logic [ADDR_W-1:0] sp_next;
  assign sp_next = sp + ADDR_W'(1);

  always_comb begin
    rt          = '0;
    rt.bit_pos  = addr[BPOS_W-1:0];
    rt.is_read  = !we;
    rt.is_write = we;
    case (kind)
      KIND_REG: begin
        rt.ram_hit  = 1'b1;
        rt.ram_addr = {{(RAM_AW-BANK_W-REG_W){1'b0}}, bank, addr[REG_W-1:0]};
      end
      KIND_DIR: begin
        if (addr[ADDR_W-1]) begin
          rt.sfr_hit  = 1'b1;
          rt.sfr_addr = addr;
        end else begin
          rt.ram_hit  = 1'b1;
          rt.ram_addr = addr[RAM_AW-1:0];
        end
      end
      KIND_IND: begin
        // upper half is not reachable through a pointer: no target at all
        if (!addr[ADDR_W-1]) begin
          rt.ram_hit  = 1'b1;
          rt.ram_addr = addr[RAM_AW-1:0];
        end
      end
      KIND_BIT: begin
        rt.is_bit = 1'b1;
        if (addr[ADDR_W-1]) begin
          rt.sfr_hit  = 1'b1;
          rt.sfr_addr = {addr[ADDR_W-1:BPOS_W], {BPOS_W{1'b0}}};
        end else begin
          rt.ram_hit  = 1'b1;
          rt.ram_addr = BIT_RAM_BASE + RAM_AW'(addr[RAM_AW-1:BPOS_W]);
        end
      end
      KIND_PUSH: begin
        rt.push     = 1'b1;
        rt.is_read  = 1'b0;
        rt.is_write = 1'b1;
        rt.ram_hit  = !sp_next[ADDR_W-1];
        rt.ram_addr = sp_next[RAM_AW-1:0];
      end
      KIND_POP: begin
        rt.pop      = 1'b1;
        rt.is_read  = 1'b1;
        rt.is_write = 1'b0;
        rt.ram_hit  = !sp[ADDR_W-1];
        rt.ram_addr = sp[RAM_AW-1:0];
      end
      default: begin
        // reserved kinds: no target, reads answer zero
      end
    endcase
  end

endmodule

// File: rtl/idm_ram_planes.sv
module idm_ram_planes #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  // one single-bit-wide plane per data bit, so a bit write is a plain
  // write enable on one plane with no read-modify-write cycle
  for (genvar i = 0; i < DW; i++) begin : g_plane
    logic mem [DEPTH];
    logic q;
    always_ff @(posedge clk) begin
      if (we && wmask[i]) mem[addr] <= wdata[i];
      if (rd_en) q <= mem[addr];
    end
    assign rdata[i] = q;
  end

endmodule

// File: rtl/idm_sfr_file.sv
module idm_sfr_file
  import idm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wmask,
  input  logic [DW-1:0] wdata,
  input  logic          sp_inc,
  input  logic          sp_dec,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] sp
);

  logic [SFR_COUNT-1:0]    hit;
  logic [SFR_COUNT*DW-1:0] flat;
  logic [DW-1:0]           sel;

  for (genvar g = 0; g < SFR_COUNT; g++) begin : g_cell
    localparam bit            IS_SP = (SFR_MAP[g] == SP_ADDR);
    localparam logic [DW-1:0] RV    = IS_SP ? DW'(SP_RESET) : '0;
    logic [DW-1:0] cell_q;

    assign hit[g] = (addr == AW'(SFR_MAP[g]));

    always_ff @(posedge clk) begin
      if (rst) begin
        cell_q <= RV;
      end else if (wr_en && hit[g]) begin
        cell_q <= (cell_q & ~wmask) | (wdata & wmask);
      end else if (IS_SP && sp_inc) begin
        cell_q <= cell_q + DW'(1);
      end else if (IS_SP && sp_dec) begin
        cell_q <= cell_q - DW'(1);
      end
    end

    assign flat[g*DW +: DW] = cell_q;
    if (IS_SP) begin : g_sp_out
      assign sp = cell_q;
    end
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < SFR_COUNT; i++) begin
      if (hit[i]) sel = sel | flat[i*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= sel;
  end

endmodule

// File: rtl/idm_unit.sv
module idm_unit
  import idm_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic [2:0]  req_kind,
  input  logic [7:0]  req_addr,
  input  logic        req_we,
  input  logic [7:0]  req_wdata,
  input  logic        req_wbit,
  input  logic [1:0]  bank_sel,
  output logic        rsp_valid,
  output logic [7:0]  rsp_data,
  output logic        rsp_bit
);

  route_t              rt;
  logic [DATA_W-1:0]   sp_cur;
  logic [DATA_W-1:0]   wmask;
  logic [DATA_W-1:0]   wval;
  logic [DATA_W-1:0]   ram_q;
  logic [DATA_W-1:0]   sfr_q;
  logic                ram_rd, ram_wr, sfr_rd, sfr_wr;
  logic                src_ram_q, src_sfr_q, bit_q;
  logic [BPOS_W-1:0]   pos_q;

  idm_route u_route (
    .kind (req_kind),
    .addr (req_addr),
    .we   (req_we),
    .bank (bank_sel),
    .sp   (sp_cur),
    .rt   (rt)
  );

  assign wmask = rt.is_bit ? (DATA_W'(1) << rt.bit_pos) : '1;
  assign wval  = rt.is_bit ? {DATA_W{req_wbit}} : req_wdata;

  assign ram_rd = req_valid && rt.is_read  && rt.ram_hit;
  assign ram_wr = req_valid && rt.is_write && rt.ram_hit;
  assign sfr_rd = req_valid && rt.is_read  && rt.sfr_hit;
  assign sfr_wr = req_valid && rt.is_write && rt.sfr_hit;

  idm_ram_planes #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk   (clk),
    .rd_en (ram_rd),
    .we    (ram_wr),
    .addr  (rt.ram_addr),
    .wmask (wmask),
    .wdata (wval),
    .rdata (ram_q)
  );

  idm_sfr_file #(.AW(ADDR_W), .DW(DATA_W)) u_sfr (
    .clk    (clk),
    .rst    (rst),
    .rd_en  (sfr_rd),
    .wr_en  (sfr_wr),
    .addr   (rt.sfr_addr),
    .wmask  (wmask),
    .wdata  (wval),
    .sp_inc (req_valid && rt.push),
    .sp_dec (req_valid && rt.pop),
    .rdata  (sfr_q),
    .sp     (sp_cur)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      src_ram_q <= 1'b0;
      src_sfr_q <= 1'b0;
      bit_q     <= 1'b0;
      pos_q     <= '0;
    end else begin
      rsp_valid <= req_valid && rt.is_read;
      src_ram_q <= ram_rd;
      src_sfr_q <= sfr_rd;
      bit_q     <= req_valid && rt.is_read && rt.is_bit;
      pos_q     <= rt.bit_pos;
    end
  end

  always_comb begin
    if (src_ram_q)      rsp_data = ram_q;
    else if (src_sfr_q) rsp_data = sfr_q;
    else                rsp_data = '0;
  end

  assign rsp_bit = bit_q && rsp_data[pos_q];

endmodule

// File: rtl/idm_checker.sv
module idm_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic [2:0] req_kind,
  input logic [7:0] req_addr,
  input logic       req_we,
  input logic       rsp_valid,
  input logic [7:0] rsp_data,
  input logic [7:0] sp_cur
);

  logic rd_req;
  assign rd_req = req_valid && ((req_kind == 3'd5) || ((req_kind != 3'd4) && !req_we));

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (sp_cur == 8'h07 && !rsp_valid));

  a_r10_resp_next: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  a_r10_no_resp: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !rsp_valid);

  a_r5_ind_high_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd2 && req_addr[7] && !req_we) |=> (rsp_data == 8'h00));

  a_r8_push_step: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd4) |=> (sp_cur == 8'($past(sp_cur) + 8'd1)));

  a_r8_pop_step: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 3'd5) |=> (sp_cur == 8'($past(sp_cur) - 8'd1)));

  a_r11_reserved_kind: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind[2:1] == 2'b11) |=> (rsp_data == 8'h00 && $stable(sp_cur)));

endmodule

bind idm_unit idm_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_addr  (req_addr),
  .req_we    (req_we),
  .rsp_valid (rsp_valid),
  .rsp_data  (rsp_data),
  .sp_cur    (sp_cur)
);

// File: tb/sim_idm_unit.sv
module sim_idm_unit;
  import idm_pkg::*;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = '0;
  logic [7:0] req_addr = '0;
  logic       req_we = 1'b0;
  logic [7:0] req_wdata = '0;
  logic       req_wbit = 1'b0;
  logic [1:0] bank_sel = '0;
  logic       rsp_valid;
  logic [7:0] rsp_data;
  logic       rsp_bit;

  always #4 clk = ~clk;

  idm_unit u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .req_wbit(req_wbit), .bank_sel(bank_sel), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .rsp_bit(rsp_bit)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] m_ram [128];
  logic [7:0] m_sfr [256];

  function automatic bit impl(input logic [7:0] a);
    for (int i = 0; i < SFR_COUNT; i++) if (SFR_MAP[i] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // one request; called at a falling edge, returns at the next falling edge
  task automatic do_req(input logic [2:0] k, input logic [7:0] a, input logic we,
                        input logic [7:0] wd, input logic wb, input logic [1:0] bk,
                        input string tag_in);
    logic [7:0] sp = m_sfr[8'h81];
    logic [7:0] exp_d = 8'h00;
    logic       exp_v;
    logic       is_bit = 1'b0;
    logic [6:0] ra;
    logic [7:0] sa;
    logic [2:0] pos = a[2:0];
    string      tag = "R11";
    exp_v = !we;
    case (k)
      KIND_REG: begin
        tag = "R2"; ra = {2'b00, bk, a[2:0]};
        if (we) m_ram[ra] = wd; else exp_d = m_ram[ra];
      end
      KIND_DIR: begin
        if (a[7]) begin
          tag = "R4";
          if (we) begin if (impl(a)) m_sfr[a] = wd; end
          else exp_d = impl(a) ? m_sfr[a] : 8'h00;
        end else begin
          tag = "R3";
          if (we) m_ram[a[6:0]] = wd; else exp_d = m_ram[a[6:0]];
        end
      end
      KIND_IND: begin
        if (a[7]) tag = "R5";
        else begin
          tag = "R3";
          if (we) m_ram[a[6:0]] = wd; else exp_d = m_ram[a[6:0]];
        end
      end
      KIND_BIT: begin
        is_bit = 1'b1;
        if (a[7]) begin
          tag = "R7"; sa = {a[7:3], 3'b000};
          if (impl(sa)) begin
            if (we) m_sfr[sa][pos] = wb; else exp_d = m_sfr[sa];
          end
        end else begin
          tag = "R6"; ra = 7'h20 + 7'(a[6:3]);
          if (we) m_ram[ra][pos] = wb; else exp_d = m_ram[ra];
        end
      end
      KIND_PUSH: begin
        tag = "R8"; exp_v = 1'b0; sp = sp + 8'd1;
        if (!sp[7]) m_ram[sp[6:0]] = wd;
        else tag = "R9";
        m_sfr[8'h81] = sp;
      end
      KIND_POP: begin
        tag = sp[7] ? "R9" : "R8"; exp_v = 1'b1;
        exp_d = sp[7] ? 8'h00 : m_ram[sp[6:0]];
        m_sfr[8'h81] = sp - 8'd1;
      end
      default: tag = "R11";
    endcase
    if (tag_in != "") tag = tag_in;
    req_kind = k; req_addr = a; req_we = we; req_wdata = wd; req_wbit = wb;
    bank_sel = bk; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, "/R10 valid"}, {7'd0, rsp_valid}, {7'd0, exp_v});
    if (exp_v) begin
      check(tag, rsp_data, exp_d);
      if (is_bit) check({tag, " bit"}, {7'd0, rsp_bit}, {7'd0, exp_d[pos]});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5813));
    for (int i = 0; i < 256; i++) m_sfr[i] = 8'h00;
    m_sfr[8'h81] = 8'h07;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", {7'd0, rsp_valid}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 valid after reset", {7'd0, rsp_valid}, 8'h00);
    do_req(KIND_DIR, 8'h81, 1'b0, 8'h00, 1'b0, 2'd0, "R1");

    // fill RAM so model and design agree
    for (int i = 0; i < 128; i++)
      do_req(KIND_DIR, 8'(i), 1'b1, 8'(i * 37 + 5), 1'b0, 2'd0, "");

    // R2: banked registers, upper index bits ignored
    do_req(KIND_REG, 8'hFB, 1'b1, 8'hA5, 1'b0, 2'd2, "R2");
    do_req(KIND_DIR, 8'h13, 1'b0, 8'h00, 1'b0, 2'd0, "R2 via direct");
    do_req(KIND_REG, 8'h07, 1'b0, 8'h00, 1'b0, 2'd3, "R2");
    // R3: indirect and direct share RAM
    do_req(KIND_IND, 8'h45, 1'b1, 8'h3C, 1'b0, 2'd0, "R3");
    do_req(KIND_DIR, 8'h45, 1'b0, 8'h00, 1'b0, 2'd0, "R3");
    // R4: implemented and unimplemented register addresses
    do_req(KIND_DIR, 8'hE0, 1'b1, 8'h5A, 1'b0, 2'd0, "R4");
    do_req(KIND_DIR, 8'hE0, 1'b0, 8'h00, 1'b0, 2'd0, "R4");
    do_req(KIND_DIR, 8'h84, 1'b1, 8'hFF, 1'b0, 2'd0, "R4");
    do_req(KIND_DIR, 8'h84, 1'b0, 8'h00, 1'b0, 2'd0, "R4 unimpl");
    // R5: indirect to upper half ignored
    do_req(KIND_IND, 8'hE0, 1'b1, 8'h11, 1'b0, 2'd0, "R5");
    do_req(KIND_DIR, 8'hE0, 1'b0, 8'h00, 1'b0, 2'd0, "R5 untouched");
    do_req(KIND_IND, 8'hE0, 1'b0, 8'h00, 1'b0, 2'd0, "R5");
    // R6: RAM bit area
    do_req(KIND_DIR, 8'h2F, 1'b1, 8'h00, 1'b0, 2'd0, "");
    do_req(KIND_BIT, 8'h7D, 1'b1, 8'h00, 1'b1, 2'd0, "R6");
    do_req(KIND_DIR, 8'h2F, 1'b0, 8'h00, 1'b0, 2'd0, "R6 one bit");
    do_req(KIND_BIT, 8'h7D, 1'b0, 8'h00, 1'b0, 2'd0, "R6");
    // R7: register bits, implemented and not
    do_req(KIND_BIT, 8'hF3, 1'b1, 8'h00, 1'b1, 2'd0, "R7");
    do_req(KIND_DIR, 8'hF0, 1'b0, 8'h00, 1'b0, 2'd0, "R7 one bit");
    do_req(KIND_BIT, 8'h8A, 1'b1, 8'h00, 1'b1, 2'd0, "R7 unimpl");
    do_req(KIND_BIT, 8'h8A, 1'b0, 8'h00, 1'b0, 2'd0, "R7 unimpl");
    // R8/R9: stack edges
    do_req(KIND_PUSH, 8'h00, 1'b0, 8'hC3, 1'b0, 2'd0, "R8");
    do_req(KIND_DIR, 8'h08, 1'b0, 8'h00, 1'b0, 2'd0, "R8 push data");
    do_req(KIND_POP, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, "R8");
    do_req(KIND_DIR, 8'h81, 1'b1, 8'h7F, 1'b0, 2'd0, "");
    do_req(KIND_PUSH, 8'h00, 1'b0, 8'h99, 1'b0, 2'd0, "R9");
    do_req(KIND_DIR, 8'h81, 1'b0, 8'h00, 1'b0, 2'd0, "R9 sp moved");
    do_req(KIND_POP, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, "R9");
    do_req(KIND_DIR, 8'h81, 1'b1, 8'hFF, 1'b0, 2'd0, "");
    do_req(KIND_PUSH, 8'h00, 1'b0, 8'h6E, 1'b0, 2'd0, "R8 wrap");
    do_req(KIND_DIR, 8'h00, 1'b0, 8'h00, 1'b0, 2'd0, "R8 wrap data");
    // R11: reserved kinds
    do_req(3'd6, 8'h10, 1'b1, 8'hEE, 1'b0, 2'd0, "R11");
    do_req(3'd7, 8'h10, 1'b0, 8'h00, 1'b0, 2'd0, "R11");
    do_req(KIND_DIR, 8'h10, 1'b0, 8'h00, 1'b0, 2'd0, "R11 untouched");
    do_req(KIND_DIR, 8'h81, 1'b1, 8'h30, 1'b0, 2'd0, "");

    for (int n = 0; n < 2000; n++) begin
      logic [3:0] r = 4'($urandom % 16);
      logic [2:0] k;
      logic [7:0] a = 8'($urandom);
      if (r < 3)       k = KIND_REG;
      else if (r < 6)  k = KIND_DIR;
      else if (r < 8)  k = KIND_IND;
      else if (r < 11) k = KIND_BIT;
      else if (r < 13) k = KIND_PUSH;
      else if (r < 15) k = KIND_POP;
      else             k = 3'd6 + 3'($urandom % 2);
      if (k == KIND_DIR && a[7] && ($urandom % 2) == 1) a = SFR_MAP[$urandom % SFR_COUNT];
      if (k == KIND_DIR && a == 8'h81 && ($urandom % 4) != 0) a = 8'h82;
      if ($urandom % 4 == 0) begin
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 idle", {7'd0, rsp_valid}, 8'h00);
      end
      do_req(k, a, 1'($urandom), 8'($urandom), 1'($urandom), 2'($urandom), "");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule